// File: doc/BRIEF.md
# Frame-Aligned Clock Divider and Frame Pulse Generator

This block runs entirely in a single fast clock domain. From that high-rate clock it derives a slower divided clock, whose rate is the high rate divided by a configurable ratio of 2, 3, 4 or 5. It also produces a frame pulse once per frame, where the frame is the 8 kHz period measured in high-rate cycles. Every rising edge of the divided clock coincides with a rising edge of the high-rate clock. The frame pulse always starts together with a divided-clock rising edge.

An external frame-sync input can pin the phase of both outputs to a system frame. It may toggle at 8 kHz or at any integer subrate, or it may sit at a constant level. The input passes through a two-stage synchronizer, and its rising edges are compared with the frame position the block expects. An edge on the expected boundary leaves the phase untouched and builds lock. An edge anywhere else restarts both counters and drops lock. When no edges arrive, the counters run freely.

The pulse is either long, lasting one divided-clock period, or short, lasting half of one. Its polarity is selectable. The configuration inputs are assumed static while the block runs. The frame length must be an exact multiple of the ratio.

Top module: `fsync_clkdiv`

## Requirements
- R1: While `rst_n` is low, `div_clk` is 0, `fs_out` equals `cfg_active_low` (its inactive level) and `locked` is 0. The first cycle after reset is released is the first cycle of a frame.
- R2: `cfg_ratio` is the binary ratio R (2..5). `div_clk` repeats every R high-rate cycles. It is high for floor(R/2) cycles, starting at the period start, and low for the remaining cycles.
- R3: Frames last `cfg_frame_len` cycles. `div_clk` starts a new period (rises) in the first cycle of every frame.
- R4: The frame pulse is active from the first cycle of each frame. It lasts R cycles when `cfg_short`=0 and floor(R/2) cycles when `cfg_short`=1.
- R5: With `cfg_active_low`=0 the pulse is driven as 1 on an idle 0. With `cfg_active_low`=1 it is driven as 0 on an idle 1.
- R6: When a rising edge of `sync_in` lands away from the expected boundary, a new frame begins in the cycle after the third rising clock edge. The count of edges starts with the first edge at which `sync_in` is sampled high. `div_clk` and `fs_out` follow the new phase from then on.
- R7: An edge is on time when its new frame would have begun anyway. On-time edges change no output phase. `locked` rises after the second consecutive on-time edge, and it holds when edges arrive only every Nth frame.
- R8: An edge that is not on time clears `locked` the cycle after it is detected. Two fresh on-time edges are then needed to set it again.
- R9: A `sync_in` held high or low, including held high through reset, causes no realignment and leaves `locked` unchanged.
- R10: Falling edges of `sync_in` have no effect on phase or lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ratio | input | RATIO_W | Divide ratio, 2 to 5 |
| cfg_frame_len | input | FRAME_W | Frame length in high-rate cycles, a multiple of the ratio |
| cfg_short | input | 1 | 1 selects a half-period pulse, 0 a full-period pulse |
| cfg_active_low | input | 1 | 1 makes the frame pulse active-low |
| sync_in | input | 1 | Asynchronous external frame-sync input |
| div_clk | output | 1 | Divided clock |
| fs_out | output | 1 | Frame pulse |
| locked | output | 1 | Frame phase confirmed by two consecutive on-time edges |

## Verification
The odd ratios 3 and 5 get special attention. A divider that rounded the high phase up, or that restarted late, would drift from the frame boundary and move the pulse off the divided-clock rise. Edges placed exactly on the boundary must neither shift phase nor miss lock. An edge placed mid-frame must realign exactly three clock edges after sampling and must drop lock. A design that detected levels instead of rising edges would realign over and over while `sync_in` is held high, or react to its falling edge. A synchronizer that cleared to 0 in reset would invent a spurious edge when `sync_in` is held high through reset.

// File: rtl/fsd_pkg.sv
// Package: shared types for the frame-aligned clock divider.
// Assumes nothing beyond being compiled before the modules that use it.
package fsd_pkg;

    // Progress of frame-phase confirmation.
    typedef enum logic [1:0] {
        LK_NONE   = 2'd0,
        LK_ONE    = 2'd1,
        LK_LOCKED = 2'd2
    } lock_state_e;

    // Default synchronizer depth for the asynchronous frame-sync input.
    localparam int SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/fsd_sync_edge.sv
// Module: synchronizes an asynchronous level and flags its rising edges.
// Assumes: the input is slow against clk. During reset every stage loads
// the live input, so a level held since reset is never seen as an edge.
module fsd_sync_edge #(
    parameter int STAGES = fsd_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES:0] shreg;

    // Shift the input through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= {(STAGES + 1){din}};
        end else begin
            shreg <= {shreg[STAGES-1:0], din};
        end
    end

    // Rising edge: newest synchronized level high, previous level low.
    always_comb begin
        rise = shreg[STAGES-1] & ~shreg[STAGES];
    end

endmodule

// File: rtl/fsd_frame_ctl.sv
// Module: frame position counter, boundary check of sync edges, lock state.
// Assumes: cfg_len is static and at least 2. A rising edge seen in the last
// frame cycle is on time. Any other edge restarts the frame next cycle.
module fsd_frame_ctl #(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] cfg_len,
    input  logic               sync_rise,
    output logic [FRAME_W-1:0] fpos,
    output logic [FRAME_W-1:0] fpos_nxt,
    output logic               restart,
    output logic               realign,
    output logic               ontime,
    output logic               locked
);

    import fsd_pkg::*;

    logic        at_last;
    lock_state_e lk_q;

    // Classify the current cycle and form the next frame position.
    always_comb begin
        at_last  = (fpos == (cfg_len - FRAME_W'(1)));
        ontime   = sync_rise & at_last;
        realign  = sync_rise & ~at_last;
        restart  = at_last | realign;
        fpos_nxt = restart ? '0 : fpos + FRAME_W'(1);
    end

    // Frame position register; reset parks it on the last frame cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fpos <= cfg_len - FRAME_W'(1);
        end else begin
            fpos <= fpos_nxt;
        end
    end

    // Lock state: on-time edges advance it, a realignment clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || realign) begin
            lk_q <= LK_NONE;
        end else if (ontime) begin
            lk_q <= (lk_q == LK_NONE) ? LK_ONE : LK_LOCKED;
        end
    end

    // Lock flag decoded from the registered state.
    always_comb begin
        locked = (lk_q == LK_LOCKED);
    end

endmodule

// File: rtl/fsd_divider.sv
// Module: ratio counter and registered divided clock.
// Assumes: ratio in 2..5. A restart forces a new period, and the frame length
// is a multiple of the ratio, so plain wraps stay on frame boundaries.
module fsd_divider #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic               restart,
    output logic [RATIO_W-1:0] dpos,
    output logic               div_q
);

    logic [RATIO_W-1:0] dpos_nxt;
    logic [RATIO_W-1:0] high_len;

    // Next divider position and length of the high phase.
    always_comb begin
        high_len = cfg_ratio >> 1;
        if (restart || (dpos == (cfg_ratio - RATIO_W'(1)))) begin
            dpos_nxt = '0;
        end else begin
            dpos_nxt = dpos + RATIO_W'(1);
        end
    end

    // Counter and clock register; reset parks the counter at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dpos  <= cfg_ratio - RATIO_W'(1);
            div_q <= 1'b0;
        end else begin
            dpos  <= dpos_nxt;
            div_q <= (dpos_nxt < high_len);
        end
    end

endmodule

// File: rtl/fsd_pulse.sv
// Module: frame pulse shaping with selectable width and polarity.
// Assumes: fpos_nxt is the frame position of the coming cycle.
module fsd_pulse #(
    parameter int FRAME_W = 12,
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic               cfg_short,
    input  logic               cfg_active_low,
    input  logic [FRAME_W-1:0] fpos_nxt,
    output logic               fs_q
);

    localparam int PAD_W = FRAME_W - RATIO_W;

    logic [RATIO_W-1:0] width;
    logic               act_nxt;

    // Pulse width in cycles and active state of the coming cycle.
    always_comb begin
        width   = cfg_short ? (cfg_ratio >> 1) : cfg_ratio;
        act_nxt = (fpos_nxt < {{PAD_W{1'b0}}, width});
    end

    // Output register with polarity applied; reset drives the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= cfg_active_low;
        end else begin
            fs_q <= act_nxt ^ cfg_active_low;
        end
    end

endmodule

// File: rtl/fsync_clkdiv.sv
// Module: top of the frame-aligned clock divider and frame pulse generator.
// Assumes: configuration is static while out of reset, the ratio is 2..5 and
// the frame length is a multiple of the ratio and wider than RATIO_W allows.
module fsync_clkdiv #(
    parameter int FRAME_W     = 12,
    parameter int RATIO_W     = 3,
    parameter int SYNC_STAGES = fsd_pkg::SYNC_STAGES_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [FRAME_W-1:0] cfg_frame_len,
    input  logic               cfg_short,
    input  logic               cfg_active_low,
    input  logic               sync_in,
    output logic               div_clk,
    output logic               fs_out,
    output logic               locked
);

    logic               sync_rise;
    logic [FRAME_W-1:0] frame_pos;
    logic [FRAME_W-1:0] frame_pos_nxt;
    logic               frame_restart;
    logic               realign_w;
    logic               ontime_w;
    logic [RATIO_W-1:0] div_pos;

    fsd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sync_in),
        .rise (sync_rise)
    );

    fsd_frame_ctl #(.FRAME_W(FRAME_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_len  (cfg_frame_len),
        .sync_rise(sync_rise),
        .fpos     (frame_pos),
        .fpos_nxt (frame_pos_nxt),
        .restart  (frame_restart),
        .realign  (realign_w),
        .ontime   (ontime_w),
        .locked   (locked)
    );

    fsd_divider #(.RATIO_W(RATIO_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_ratio(cfg_ratio),
        .restart  (frame_restart),
        .dpos     (div_pos),
        .div_q    (div_clk)
    );

    fsd_pulse #(.FRAME_W(FRAME_W), .RATIO_W(RATIO_W)) u_pulse (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_ratio     (cfg_ratio),
        .cfg_short     (cfg_short),
        .cfg_active_low(cfg_active_low),
        .fpos_nxt      (frame_pos_nxt),
        .fs_q          (fs_out)
    );

endmodule

// File: rtl/fsd_checker.sv
// Module: assertion checker bound to fsync_clkdiv.
// Assumes: configuration is static and legal while out of reset.
module fsd_checker #(
    parameter int FRAME_W = 12,
    parameter int RATIO_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RATIO_W-1:0] cfg_ratio,
    input logic               cfg_active_low,
    input logic               div_clk,
    input logic               fs_out,
    input logic               locked,
    input logic [FRAME_W-1:0] fpos,
    input logic [RATIO_W-1:0] dpos,
    input logic               realign,
    input logic               ontime
);

    // R3: a frame's first cycle is a divided-clock high phase.
    p_div_at_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fpos == '0) |-> div_clk);

    // R4: the frame pulse is active in a frame's first cycle.
    p_pulse_at_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fpos == '0) |-> (fs_out != cfg_active_low));

    // R2: a divider period end without a realign is followed by a rise.
    p_div_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!realign && dpos == (cfg_ratio - RATIO_W'(1))) |=> $rose(div_clk));

    // R6: a realignment restarts frame and divider together.
    p_realign_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (fpos == '0 && dpos == '0));

    // R8: a realignment drops lock.
    p_realign_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> !locked);

    // R7: lock only rises right after an on-time edge.
    p_lock_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ontime));

endmodule

bind fsync_clkdiv fsd_checker #(.FRAME_W(FRAME_W), .RATIO_W(RATIO_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_ratio     (cfg_ratio),
    .cfg_active_low(cfg_active_low),
    .div_clk       (div_clk),
    .fs_out        (fs_out),
    .locked        (locked),
    .fpos          (frame_pos),
    .dpos          (div_pos),
    .realign       (realign_w),
    .ontime        (ontime_w)
);

// File: tb/sim_fsync_clkdiv.sv
// Bench for fsync_clkdiv: a vector table of configurations walked by one loop,
// then directed sync, lock and static-input tests against a phase model.
module sim_fsync_clkdiv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_ratio = 3'd2;
    logic [11:0] cfg_len = 12'd12;
    logic        cfg_short = 1'b0;
    logic        cfg_pol = 1'b0;
    logic        sync_in = 1'b0;
    logic        div_clk, fs_out, locked;

    int n_chk = 0, n_bad = 0;
    int R = 2, L = 12;
    int p = 0, cd = 0, arm_req = 0, arm_seen = 0;
    bit mon_en = 1'b0;
    int mon_bad = 0, m_p = 0;
    logic m_div, m_fs;

    // Fields: ratio[16:14], frame length[13:2], short[1], active-low[0].
    localparam int NV = 6;
    localparam logic [16:0] VEC [NV] = '{
        {3'd2, 12'd12, 1'b0, 1'b0},
        {3'd3, 12'd18, 1'b0, 1'b0},
        {3'd4, 12'd20, 1'b1, 1'b0},
        {3'd5, 12'd30, 1'b0, 1'b1},
        {3'd5, 12'd20, 1'b1, 1'b1},
        {3'd3, 12'd24, 1'b1, 1'b0}
    };

    fsync_clkdiv u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_ratio     (cfg_ratio),
        .cfg_frame_len (cfg_len),
        .cfg_short     (cfg_short),
        .cfg_active_low(cfg_pol),
        .sync_in       (sync_in),
        .div_clk       (div_clk),
        .fs_out        (fs_out),
        .locked        (locked)
    );

    always #2.5 clk = ~clk;

    // Expected outputs at frame position pp, from R2, R4 and R5.
    function automatic logic e_div(int pp);
        return ((pp % R) < (R / 2));
    endfunction

    function automatic logic e_fs(int pp);
        int w;
        w = cfg_short ? (R / 2) : R;
        return ((pp < w) ? 1'b1 : 1'b0) ^ cfg_pol;
    endfunction

    // Phase model: free-running frame position, restarted 3 edges after an arm.
    always @(posedge clk) begin
        if (!rst_n) begin
            p <= L - 1;
            cd <= 0;
            arm_seen <= arm_req;
        end else begin
            if (cd == 1) p <= 0;
            else p <= (p == L - 1) ? 0 : p + 1;
            if (arm_req != arm_seen) begin
                cd <= 2;
                arm_seen <= arm_req;
            end else if (cd != 0) begin
                cd <= cd - 1;
            end
        end
    end

    // Output monitor sampled mid-cycle.
    always @(negedge clk) begin
        if (mon_en && (div_clk !== e_div(p) || fs_out !== e_fs(p))) begin
            if (mon_bad == 0) begin
                m_p = p;
                m_div = div_clk;
                m_fs = fs_out;
            end
            mon_bad++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic mon_chk(string tag);
        chk(mon_bad == 0, tag, mon_bad, 0);
        if (mon_bad != 0)
            $display("  first mismatch phase=%0d div=%0b fs=%0b exp_div=%0b exp_fs=%0b",
                     m_p, m_div, m_fs, e_div(m_p), e_fs(m_p));
        mon_bad = 0;
    endtask

    task automatic do_reset(logic [2:0] r, logic [11:0] len, logic sh, logic pol);
        @(negedge clk);
        mon_en = 1'b0;
        cfg_ratio = r; cfg_len = len; cfg_short = sh; cfg_pol = pol;
        R = int'(r); L = int'(len);
        rst_n = 1'b0;
        tick(3);
        chk(div_clk == 1'b0, "R1 div_clk in reset", int'(div_clk), 0);
        chk(fs_out == pol, "R1 fs_out idle in reset", int'(fs_out), int'(pol));
        chk(locked == 1'b0, "R1 locked in reset", int'(locked), 0);
        rst_n = 1'b1;
        mon_bad = 0;
        mon_en = 1'b1;
    endtask

    // Raise sync_in for 3 cycles at the negedge where the model shows pos.
    task automatic pulse_at(int pos);
        @(negedge clk);
        while (p != pos) @(negedge clk);
        sync_in = 1'b1;
        arm_req++;
        tick(3);
        sync_in = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // Vector table: R1 to R5 across ratios, widths and polarities.
        for (int i = 0; i < NV; i++) begin
            do_reset(VEC[i][16:14], VEC[i][13:2], VEC[i][1], VEC[i][0]);
            chk(1'b1, "R1 frame start", 0, 0);
            tick(3 * L);
            mon_chk("R2 R3 R4 R5 free-run vector");
        end

        // Lock sequence with ratio 4, frame 20, long pulse.
        do_reset(3'd4, 12'd20, 1'b0, 1'b0);
        tick(25);
        pulse_at(L - 3);
        tick(4);
        chk(locked == 1'b0, "R7 one on-time edge", int'(locked), 0);
        pulse_at(L - 3);
        tick(4);
        chk(locked == 1'b1, "R7 two on-time edges", int'(locked), 1);
        mon_chk("R7 on-time edges keep phase");
        tick(2 * L);
        pulse_at(L - 3);
        tick(4);
        chk(locked == 1'b1, "R7 subrate edge keeps lock", int'(locked), 1);
        mon_chk("R7 subrate phase");

        // Off-boundary edge realigns and unlocks.
        pulse_at(5);
        tick(2 * L);
        chk(locked == 1'b0, "R8 off-time edge unlocks", int'(locked), 0);
        mon_chk("R6 realign to off-time edge");
        pulse_at(L - 3);
        tick(4);
        chk(locked == 1'b0, "R8 one fresh edge not enough", int'(locked), 0);
        pulse_at(L - 3);
        tick(4);
        chk(locked == 1'b1, "R8 relock after two edges", int'(locked), 1);

        // Held high after an on-time rise, then a falling edge mid-frame.
        @(negedge clk);
        while (p != L - 3) @(negedge clk);
        sync_in = 1'b1;
        arm_req++;
        tick(4 * L);
        chk(locked == 1'b1, "R9 static high keeps lock", int'(locked), 1);
        mon_chk("R9 static high no realign");
        @(negedge clk);
        while (p != 7) @(negedge clk);
        sync_in = 1'b0;
        tick(3 * L);
        chk(locked == 1'b1, "R10 falling edge ignored lock", int'(locked), 1);
        mon_chk("R10 falling edge ignored phase R9 static low");

        // Held high through reset: no spurious edge after release.
        sync_in = 1'b1;
        do_reset(3'd5, 12'd20, 1'b1, 1'b1);
        tick(3 * L);
        mon_chk("R9 high through reset no realign");
        chk(locked == 1'b0, "R9 high through reset lock", int'(locked), 0);
        sync_in = 1'b0;

        // Off-time edge with odd ratio 3 and active-low pulse.
        do_reset(3'd3, 12'd18, 1'b0, 1'b1);
        tick(10);
        pulse_at(4);
        tick(2 * L);
        mon_chk("R6 realign odd ratio");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule